// File: doc/BRIEF.md
# Static Crossbar Route Sequencer

This block sequences the static-network crossbar of one mesh tile. It fetches one instruction per cycle from a small synchronous instruction store. Each instruction carries two parts that run in the same cycle. The first is a control operation: a register move, a conditional branch, an absolute jump or a jump through a source value. The second is a route field that moves single words from the tile's input channels to its output channels. The inputs are the north, east, south and west inputs and the local processor's output queue. The outputs are the north, east, south and west outputs and the processor's input queue.

The control operation may read any of the five input channels directly as its operand, and doing so consumes the word. The same word can also be routed to any number of outputs in that cycle. The neighbouring queues appear only as per-channel valid/dequeue and ready/push signals. The instruction acts as a unit: if any channel it names cannot take part, the whole instruction waits. The program is fixed by a parameter.

Top module: `xbar_route_seq`

## Requirements
- R1: While reset is high, no dequeue or push strobe is asserted. The first instruction executed after reset is the one at address 0, and `pc_o` reads 0 in that cycle.
- R2: An executed instruction that does not redirect control advances `pc_o` by one on the next cycle. The count wraps from DEPTH-1 to 0.
- R3: Instruction word, from the MSB down: opcode (3 bits), destination register (2 bits), source (4 bits), immediate target (log2 DEPTH bits), route (15 bits). Opcodes: 0 nop, 1 move, 2 branch-if-zero, 3 branch-if-nonzero, 4 jump, 5 jump-to-source; codes 6 and 7 act as nop. Source codes 0 to 3 select registers r0 to r3. Codes 4 to 8 select the north, east, south, west and processor-output channels. A move writes the source value into the destination register; the four registers reset to zero.
- R4: Route field bits [3o+2:3o] select the source for output o, with o = 0 north, 1 east, 2 south, 3 west, 4 processor input. Selector codes: 0 none, 1 north in, 2 east in, 3 south in, 4 west in, 5 processor out. Codes 6 and 7 act as none. On an executed instruction, each output with a source pushes that source's word, and one input may feed several outputs at once.
- R5: If any input channel named by the operand or the route lacks valid data, or any routed output is not ready, the instruction stalls. No strobe is asserted, no register is written and `pc_o` holds.
- R6: A branch-if-zero or branch-if-nonzero whose test holds loads the immediate target into `pc_o` on the next cycle, with no delay slot. Otherwise it falls through as in R2.
- R7: A jump loads the immediate target. A jump-to-source loads the low log2(DEPTH) bits of the source value. When that source is a channel, the same word can be routed onward in the same cycle.
- R8: An executed instruction dequeues each named input channel exactly once, whether the channel is read by the operand, by the route or by both, and dequeues no other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 5*DW | Input channel words, slot i at [i*DW +: DW], order N,E,S,W,processor-out |
| in_valid | input | 5 | Input channel holds a word |
| in_deq | output | 5 | Consume the word of an input channel this cycle |
| out_data | output | 5*DW | Output channel words, slot o at [o*DW +: DW], order N,E,S,W,processor-in |
| out_ready | input | 5 | Output channel can accept a word |
| out_push | output | 5 | Write out_data slot into the output channel this cycle |
| pc_o | output | log2(DEPTH) | Address of the instruction being executed |

## Verification
The control operation and the route field can claim the same input channel in one cycle. The program reads the west input as a move operand while routing it to the processor input. It also jumps through the processor-output word while fanning that word out to two outputs. Random valid and ready patterns hit these instructions in both stalled and executed cycles. The bench checks that exactly one dequeue strobe appears, that every routed copy matches the operand word, and that the register or jump target built from that word shows up in `pc_o` one cycle later.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
   localparam int NPORT  = 5;
   localparam int OPW    = 3;
   localparam int DSTW   = 2;
   localparam int SRCW   = 4;
   localparam int SELW   = 3;
   localparam int NREG   = 4;
   localparam int ROUTEW = NPORT * SELW;
   localparam int FIXW   = OPW + DSTW + SRCW + ROUTEW;
   localparam logic [SRCW-1:0] SRC_PORT0 = 4'd4;

   typedef enum logic [OPW-1:0] {
      OP_NOP  = 3'd0,
      OP_MOVE = 3'd1,
      OP_BEQZ = 3'd2,
      OP_BNEZ = 3'd3,
      OP_JUMP = 3'd4,
      OP_JSRC = 3'd5
   } op_e;
endpackage

// File: rtl/xrs_imem.sv
module xrs_imem #(
   parameter int DEPTH = 16,
   parameter int IW    = 28,
   parameter logic [DEPTH*IW-1:0] CONTENT = '0
) (
   input  logic                     clk,
   input  logic [$clog2(DEPTH)-1:0] rd_addr,
   output logic [IW-1:0]            rd_data
);
   always_ff @(posedge clk) begin
      rd_data <= CONTENT[rd_addr*IW +: IW];
   end
endmodule

// File: rtl/xrs_regfile.sv
module xrs_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 4,
   localparam int AW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] regs [NREG];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (we) begin
         regs[waddr] <= wdata;
      end
   end

   assign rdata = regs[raddr];
endmodule

// File: rtl/xrs_xbar.sv
module xrs_xbar
   import xrs_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                enable,
   input  logic [ROUTEW-1:0]   route,
   input  logic [NPORT-1:0]    src_need,
   input  logic [NPORT*DW-1:0] in_data,
   input  logic [NPORT-1:0]    in_valid,
   input  logic [NPORT-1:0]    out_ready,
   output logic [NPORT-1:0]    in_deq,
   output logic [NPORT*DW-1:0] out_data,
   output logic [NPORT-1:0]    out_push,
   output logic                fire
);
   logic [SELW-1:0]  sel  [NPORT];
   logic [SELW-1:0]  sidx [NPORT];
   logic [NPORT-1:0] out_act;
   logic [NPORT-1:0] need;
   logic             stall;

   for (genvar o = 0; o < NPORT; o++) begin : g_out
      logic [DW-1:0] word;
      assign sel[o]     = route[o*SELW +: SELW];
      assign out_act[o] = (sel[o] != '0) && (sel[o] <= SELW'(NPORT));
      assign sidx[o]    = sel[o] - 1'b1;
      always_comb begin
         word = '0;
         for (int i = 0; i < NPORT; i++)
            if (out_act[o] && (sidx[o] == SELW'(i))) word = in_data[i*DW +: DW];
      end
      assign out_data[o*DW +: DW] = word;

      // R4: every pushed output consumes the input it copies
      p_push_has_deq_r4: assert property (@(posedge clk) disable iff (rst)
         out_push[o] |-> in_deq[sidx[o]]);
   end

   always_comb begin
      need = src_need;
      for (int o = 0; o < NPORT; o++)
         for (int i = 0; i < NPORT; i++)
            if (out_act[o] && (sidx[o] == SELW'(i))) need[i] = 1'b1;
   end

   assign stall    = (|(need & ~in_valid)) || (|(out_act & ~out_ready));
   assign fire     = enable && !stall;
   assign in_deq   = {NPORT{fire}} & need;
   assign out_push = {NPORT{fire}} & out_act;

   p_deq_needs_valid_r5: assert property (@(posedge clk) disable iff (rst)
      (in_deq & ~in_valid) == '0);
   p_push_needs_ready_r5: assert property (@(posedge clk) disable iff (rst)
      (out_push & ~out_ready) == '0);
endmodule

// File: rtl/xbar_route_seq.sv
module xbar_route_seq
   import xrs_pkg::*;
#(
   parameter int DW    = 32,
   parameter int DEPTH = 16,
   parameter logic [DEPTH*(FIXW+$clog2(DEPTH))-1:0] PROGRAM = '0
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic [NPORT*DW-1:0]      in_data,
   input  logic [NPORT-1:0]         in_valid,
   output logic [NPORT-1:0]         in_deq,
   output logic [NPORT*DW-1:0]      out_data,
   input  logic [NPORT-1:0]         out_ready,
   output logic [NPORT-1:0]         out_push,
   output logic [$clog2(DEPTH)-1:0] pc_o
);
   localparam int PCW = $clog2(DEPTH);
   localparam int IW  = FIXW + PCW;

   initial begin
      a_depth_pow2: assert (DEPTH >= 2 && DEPTH == (1 << PCW))
         else $error("DEPTH must be a power of two, at least 2");
      a_dw_fits_pc: assert (DW >= PCW)
         else $error("DW must cover the program counter");
   end

   logic [IW-1:0]     instr;
   logic [PCW-1:0]    pc_q, next_pc, rd_addr, imm, tgt;
   logic [OPW-1:0]    op;
   logic [DSTW-1:0]   dst;
   logic [SRCW-1:0]   src;
   logic [ROUTEW-1:0] route;
   logic [NPORT-1:0]  src_need;
   logic [DW-1:0]     rf_rdata, opval;
   logic              uses_src, fire, taken;

   xrs_imem #(.DEPTH(DEPTH), .IW(IW), .CONTENT(PROGRAM)) u_imem (
      .clk(clk), .rd_addr(rd_addr), .rd_data(instr));

   assign op    = instr[IW-1 -: OPW];
   assign dst   = instr[IW-OPW-1 -: DSTW];
   assign src   = instr[IW-OPW-DSTW-1 -: SRCW];
   assign imm   = instr[ROUTEW +: PCW];
   assign route = instr[ROUTEW-1:0];

   assign uses_src = (op == OP_MOVE) || (op == OP_BEQZ) ||
                     (op == OP_BNEZ) || (op == OP_JSRC);

   always_comb begin
      src_need = '0;
      opval    = '0;
      if (src < SRC_PORT0) opval = rf_rdata;
      for (int i = 0; i < NPORT; i++) begin
         if (src == SRC_PORT0 + SRCW'(i)) begin
            src_need[i] = uses_src;
            opval       = in_data[i*DW +: DW];
         end
      end
   end

   xrs_regfile #(.DW(DW), .NREG(NREG)) u_rf (
      .clk(clk), .rst(rst),
      .we(fire && (op == OP_MOVE)), .waddr(dst), .wdata(opval),
      .raddr(src[DSTW-1:0]), .rdata(rf_rdata));

   xrs_xbar #(.DW(DW)) u_xbar (
      .clk(clk), .rst(rst), .enable(!rst), .route(route), .src_need(src_need),
      .in_data(in_data), .in_valid(in_valid), .out_ready(out_ready),
      .in_deq(in_deq), .out_data(out_data), .out_push(out_push), .fire(fire));

   always_comb begin
      taken = 1'b0;
      tgt   = imm;
      case (op)
         OP_BEQZ: taken = (opval == '0);
         OP_BNEZ: taken = (opval != '0);
         OP_JUMP: taken = 1'b1;
         OP_JSRC: begin taken = 1'b1; tgt = opval[PCW-1:0]; end
         default: taken = 1'b0;
      endcase
   end

   assign next_pc = !fire ? pc_q : (taken ? tgt : pc_q + 1'b1);
   assign rd_addr = rst ? '0 : next_pc;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= next_pc;
   end

   assign pc_o = pc_q;

   p_stall_holds_pc_r5: assert property (@(posedge clk) disable iff (rst)
      (!fire) |=> (pc_q == $past(pc_q)));
   p_jump_abs_r7: assert property (@(posedge clk) disable iff (rst)
      (fire && (op == OP_JUMP)) |=> (pc_q == $past(imm)));
   p_reset_idle_r1: assert property (@(posedge clk)
      rst |-> (in_deq == '0 && out_push == '0));
endmodule

// File: tb/xbar_route_seq_test.sv
module xbar_route_seq_test;
   localparam int DW = 32, DEPTH = 16, PCW = 4, NP = 5;
   localparam int IW = 24 + PCW;

   function automatic logic [IW-1:0] enc(int op, int dst, int src, int imm,
                                         int n, int e, int s, int w, int p);
      return {3'(op), 2'(dst), 4'(src), 4'(imm), 3'(p), 3'(w), 3'(s), 3'(e), 3'(n)};
   endfunction

   function automatic logic [DEPTH*IW-1:0] build_prog();
      logic [DEPTH*IW-1:0] pr = '0;
      pr[0*IW +: IW]  = enc(1, 1, 7, 0, 2, 0, 2, 0, 4); // move r1<-W, N,S<-E, P<-W
      pr[1*IW +: IW]  = enc(5, 0, 1, 0, 0, 0, 0, 0, 0); // jump to r1
      pr[4*IW +: IW]  = enc(2, 0, 4, 8, 0, 1, 0, 0, 0); // beqz N ->8, E<-N
      pr[5*IW +: IW]  = enc(3, 0, 1, 7, 0, 0, 0, 0, 0); // bnez r1 ->7
      pr[7*IW +: IW]  = enc(5, 0, 8, 0, 5, 0, 0, 5, 0); // jump to P, N,W<-P
      pr[8*IW +: IW]  = enc(1, 2, 6, 0, 0, 0, 0, 0, 3); // move r2<-S, P<-S
      pr[9*IW +: IW]  = enc(4, 0, 0, 14, 0, 7, 2, 6, 0); // jump 14, reserved E/W
      pr[14*IW +: IW] = enc(1, 3, 2, 0, 0, 0, 0, 0, 0); // move r3<-r2
      pr[15*IW +: IW] = enc(6, 0, 0, 0, 0, 0, 0, 0, 0); // reserved op: nop, wraps
      return pr;
   endfunction

   localparam logic [DEPTH*IW-1:0] PROG = build_prog();

   logic              clk = 0, rst = 1;
   logic [NP*DW-1:0]  in_data = '0, out_data;
   logic [NP-1:0]     in_valid = '0, in_deq, out_ready = '0, out_push;
   logic [PCW-1:0]    pc_o;

   xbar_route_seq #(.DW(DW), .DEPTH(DEPTH), .PROGRAM(PROG)) uut (
      .clk(clk), .rst(rst), .in_data(in_data), .in_valid(in_valid), .in_deq(in_deq),
      .out_data(out_data), .out_ready(out_ready), .out_push(out_push), .pc_o(pc_o));

   always #4 clk = ~clk;

   int nchk = 0, nfail = 0;
   bit done = 0;

   task automatic chk(string tag, string what, logic [NP*DW-1:0] got, logic [NP*DW-1:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
      end
   endtask

   int          mpc = 0;
   logic [DW-1:0] mreg [4];
   string       pc_tag = "R1";

   task automatic drive(bit all_ok);
      for (int i = 0; i < NP; i++) begin
         logic [DW-1:0] d = $urandom();
         if (i == 3 && ($urandom() % 4) != 0) d[3:0] = 4'd4;
         if (i == 4 && ($urandom() % 4) != 0) d[3:0] = 4'd9;
         if (i == 0 && ($urandom() % 2) != 0) d = '0;
         in_data[i*DW +: DW] = d;
         in_valid[i]  = all_ok ? 1'b1 : (($urandom() % 5) != 0);
         out_ready[i] = all_ok ? 1'b1 : (($urandom() % 5) != 0);
      end
   endtask

   task automatic step_model();
      logic [IW-1:0] w = PROG[mpc*IW +: IW];
      int op = int'(w[27:25]), dst = int'(w[24:23]), src = int'(w[22:19]), imm = int'(w[18:15]);
      logic [NP-1:0] need = '0, act = '0, edeq, epush;
      logic [NP*DW-1:0] edata = '0, mask = '0;
      logic [DW-1:0] v = '0;
      bit usesrc = (op == 1 || op == 2 || op == 3 || op == 5);
      bit stall, red;
      int npc;
      if (src < 4) v = mreg[src];
      else if (src <= 8) begin
         v = in_data[(src-4)*DW +: DW];
         if (usesrc) need[src-4] = 1'b1;
      end
      for (int o = 0; o < NP; o++) begin
         int c = int'(w[o*3 +: 3]);
         if (c >= 1 && c <= 5) begin
            act[o] = 1'b1; need[c-1] = 1'b1;
            edata[o*DW +: DW] = in_data[(c-1)*DW +: DW];
            mask[o*DW +: DW] = '1;
         end
      end
      stall = (|(need & ~in_valid)) || (|(act & ~out_ready));
      edeq  = stall ? '0 : need;
      epush = stall ? '0 : act;
      chk(pc_tag, "pc_o", NP*DW'(pc_o), NP*DW'(mpc));
      chk(stall ? "R5" : "R8", "in_deq", NP*DW'(in_deq), NP*DW'(edeq));
      chk(stall ? "R5" : "R4", "out_push", NP*DW'(out_push), NP*DW'(epush));
      if (!stall && act != '0) chk("R4", "out_data", out_data & mask, edata);
      npc = (mpc + 1) % DEPTH; red = 0;
      if (stall) begin npc = mpc; pc_tag = "R5"; end
      else begin
         pc_tag = "R2";
         case (op)
            1: mreg[dst] = v;
            2: if (v == '0) begin npc = imm; red = 1; end
            3: if (v != '0) begin npc = imm; red = 1; end
            4: begin npc = imm; red = 1; end
            5: begin npc = int'(v[3:0]); red = 1; end
            default: ;
         endcase
         if (red) pc_tag = (op == 5) ? ((src < 4) ? "R3" : "R7") : ((op == 4) ? "R7" : "R6");
      end
      mpc = npc;
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 4; i++) mreg[i] = '0;
      repeat (3) begin
         @(negedge clk); drive(1); #1;
         chk("R1", "in_deq during reset", NP*DW'(in_deq), '0);
         chk("R1", "out_push during reset", NP*DW'(out_push), '0);
      end
      @(negedge clk); rst = 0;
      for (int c = 0; c < 64; c++) begin
         drive(1); #1; step_model(); @(negedge clk);
      end
      for (int c = 0; c < 4000; c++) begin
         drive(0); #1; step_model(); @(negedge clk);
      end
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         nchk++; nfail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end
endmodule